// File: doc/BRIEF.md
# Forwarding Multiply-Accumulate Datapath

This block is the arithmetic core used for multi-word product-scanning multiplication on a 16-bit datapath. Each cycle it can multiply two 16-bit operands, unsigned, and add the 32-bit product into a 48-bit accumulator. The accumulator is three words wide, so long runs of column products keep their carries. An operand comes from one of four work registers or straight from the data memory. A word arriving from the single-port memory can be multiplied in the same cycle it arrives, with no move into a work register first.

Per-cycle control inputs stand in for instruction decode. A read request may be issued in the same cycle as a multiply-accumulate, so loads and arithmetic overlap. A store-and-shift operation places the low accumulator word on the memory write port and drops it from the accumulator with a one-word right shift. A move operation can copy either the incoming memory word or the low accumulator word into a work register. Used together with a store, one result reaches memory and a register in the same cycle. Carry, Zero, Negative and Overflow flags track the accumulator.

Top module: `mac_fwd_unit`

## Requirements
- R1: After the asynchronous active-low reset, accOut is 0, flagZ is 1, flagC, flagN and flagV are 0, mulInA and mulInB are 0, and memWrEn is 0.
- R2: With opMac high, the accumulator at the next edge equals its previous value plus the unsigned product mulInA*mulInB, modulo 2^48.
- R3: Select codes 0 to 3 on selA and selB pick work registers 0 to 3. Code 4 picks the memory word. The memory word is memRdData itself in the cycle after a cycle with rdIssue high. In any other cycle it is the last word captured in such a cycle.
- R4: opMove writes work register wrIdx at the clock edge. It takes the memory word when moveFromAcc is 0 and the low accumulator word when moveFromAcc is 1.
- R5: opStore drives memWrEn high and drives memWrData with the low accumulator word as it stood at the start of the cycle. opShift shifts the accumulator right by 16 bits and fills the top with zeros. When both shift and multiply are given, the product is added to the shifted value.
- R6: rdIssue may be high in the same cycle as opMac. The multiply-accumulate is unaffected, and the word returned in the next cycle is usable as an operand.
- R7: opClr zeroes all 48 accumulator bits in one cycle. It has priority over opMac and opShift. It sets flagZ and clears flagC, flagN and flagV.
- R8: After each accumulate, flagZ is 1 when the low accumulator word is 0, and flagN equals bit 15. flagC is the carry out of bit 47. flagV is 1 when bit 47 goes from 0 to 1. In cycles with neither accumulate nor clear, the flags keep their values.
- R9: In cycles without opMac, mulInA and mulInB hold the operands of the last multiply-accumulate.
- R10: opStore together with opMove and moveFromAcc=1 writes the same low accumulator word to memory and to a work register in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdIssue | input | 1 | A memory read is issued this cycle; its data returns next cycle |
| opMac | input | 1 | Multiply-accumulate |
| opClr | input | 1 | Clear accumulator |
| opShift | input | 1 | Shift accumulator right one word |
| opStore | input | 1 | Write low accumulator word to memory |
| opMove | input | 1 | Write a work register |
| moveFromAcc | input | 1 | Move source: 1 = low accumulator word, 0 = memory word |
| selA | input | 3 | Operand A select (0-3 work register, 4 memory word) |
| selB | input | 3 | Operand B select |
| wrIdx | input | 2 | Work register written by a move |
| memRdData | input | 16 | Read data from data memory |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 16 | Memory write data |
| accOut | output | 48 | Accumulator |
| mulInA | output | 16 | Multiplier operand A as applied |
| mulInB | output | 16 | Multiplier operand B as applied |
| flagC | output | 1 | Carry |
| flagZ | output | 1 | Zero |
| flagN | output | 1 | Negative |
| flagV | output | 1 | Overflow |

## Verification
The bench targets the forwarding path in two cases. In the cycle right after a read, the operand must be the live bus value. In a later cycle, the bus is driven with a different value, and the operand must be the captured word. A design that always bypassed would pick up that wrong bus value, and one that always used the latch would use a stale word. Store combined with shift checks that the stored word is the pre-shift low word and that zeros fill the top. It also checks that clear overrides a simultaneous accumulate. An accumulation run of about 65,000 maximal products drives bit 47 across its sign boundary and then out of the accumulator. This exposes a carry taken from the wrong bit or an overflow flag that never fires. Idle cycles after a multiply confirm that the multiplier operands and the flags keep their values.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int WORK_REGS = 4;
  localparam int SEL_W = $clog2(WORK_REGS + 1);
  localparam int IDX_W = $clog2(WORK_REGS);

  typedef struct packed {
    logic doClr;
    logic doMac;
    logic doShift;
    logic doStore;
    logic doMove;
    logic moveFromAcc;
    logic fwdLive;
    logic [SEL_W-1:0] selA;
    logic [SEL_W-1:0] selB;
    logic [IDX_W-1:0] wrIdx;
  } mac_strobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdIssue,
  input  logic             opMac,
  input  logic             opClr,
  input  logic             opShift,
  input  logic             opStore,
  input  logic             opMove,
  input  logic             moveFromAcc,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  input  logic [IDX_W-1:0] wrIdx,
  output mac_strobe_t      strobe
);
  // A read issued now returns its word during the next cycle.
  logic rdPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPending <= 1'b0;
    else       rdPending <= rdIssue;
  end

  always_comb begin
    strobe             = '0;
    strobe.doClr       = opClr;
    // Clear wins over any accumulator update in the same cycle.
    strobe.doMac       = opMac & ~opClr;
    strobe.doShift     = opShift & ~opClr;
    strobe.doStore     = opStore;
    strobe.doMove      = opMove;
    strobe.moveFromAcc = moveFromAcc;
    strobe.fwdLive     = rdPending;
    strobe.selA        = selA;
    strobe.selB        = selB;
    strobe.wrIdx       = wrIdx;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ACC_WORDS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mac_strobe_t       s,
  input  logic [WORD_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  output logic [WORD_W*ACC_WORDS-1:0] accOut,
  output logic [WORD_W-1:0] mulInA,
  output logic [WORD_W-1:0] mulInB,
  output logic              flagC,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagV
);
  localparam int ACC_W  = WORD_W * ACC_WORDS;
  localparam int PROD_W = 2 * WORD_W;

  logic [WORD_W-1:0] workReg [WORK_REGS];
  logic [WORD_W-1:0] loadHold, fwdWord, opA, opB, holdA, holdB;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc, base, addend, accNext;
  logic [ACC_W:0]    sum;

  // Memory word: live bus right after a read, else the captured copy.
  assign fwdWord = s.fwdLive ? memRdData : loadHold;

  always_comb begin
    opA = fwdWord;
    opB = fwdWord;
    for (int i = 0; i < WORK_REGS; i++) begin
      if (s.selA == SEL_W'(i)) opA = workReg[i];
      if (s.selB == SEL_W'(i)) opB = workReg[i];
    end
  end

  // Operand isolation: multiplier inputs only move on an active multiply.
  assign mulInA = s.doMac ? opA : holdA;
  assign mulInB = s.doMac ? opB : holdB;
  assign prod   = PROD_W'(mulInA) * PROD_W'(mulInB);

  assign base    = s.doShift ? {{WORD_W{1'b0}}, acc[ACC_W-1:WORD_W]} : acc;
  assign addend  = s.doMac ? {{(ACC_W-PROD_W){1'b0}}, prod} : '0;
  assign sum     = {1'b0, base} + {1'b0, addend};
  assign accNext = s.doClr ? '0 : sum[ACC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      holdA <= '0;
      holdB <= '0;
      flagC <= 1'b0;
      flagZ <= 1'b1;
      flagN <= 1'b0;
      flagV <= 1'b0;
    end else begin
      acc <= accNext;
      if (s.doMac) begin
        holdA <= opA;
        holdB <= opB;
      end
      if (s.doClr) begin
        flagC <= 1'b0;
        flagZ <= 1'b1;
        flagN <= 1'b0;
        flagV <= 1'b0;
      end else if (s.doMac) begin
        flagC <= sum[ACC_W];
        flagZ <= (sum[WORD_W-1:0] == '0);
        flagN <= sum[WORD_W-1];
        flagV <= ~base[ACC_W-1] & sum[ACC_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadHold <= '0;
      for (int i = 0; i < WORK_REGS; i++) workReg[i] <= '0;
    end else begin
      if (s.fwdLive) loadHold <= memRdData;
      for (int i = 0; i < WORK_REGS; i++)
        if (s.doMove && s.wrIdx == IDX_W'(i))
          workReg[i] <= s.moveFromAcc ? acc[WORD_W-1:0] : fwdWord;
    end
  end

  assign memWrEn   = s.doStore;
  assign memWrData = acc[WORD_W-1:0];
  assign accOut    = acc;

  // ---------------- assertions ----------------
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    s.doClr |=> (accOut == '0 && flagZ && !flagC));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    !s.doMac |-> (mulInA == $past(mulInA) && mulInB == $past(mulInB)));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (s.doShift && !s.doMac) |=> (accOut == ($past(accOut) >> WORD_W)));

  assert_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    s.doMac |=> (flagC == (accOut < $past(base))));

  assert_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    s.doMac |=> (flagZ == (accOut[WORD_W-1:0] == '0)));

  assert_fwd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (s.fwdLive && s.doMac && s.selA >= SEL_W'(WORK_REGS)) |-> (mulInA == memRdData));
endmodule

// File: rtl/mac_fwd_unit.sv
module mac_fwd_unit
  import mac_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ACC_WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rdIssue,
  input  logic                        opMac,
  input  logic                        opClr,
  input  logic                        opShift,
  input  logic                        opStore,
  input  logic                        opMove,
  input  logic                        moveFromAcc,
  input  logic [SEL_W-1:0]            selA,
  input  logic [SEL_W-1:0]            selB,
  input  logic [IDX_W-1:0]            wrIdx,
  input  logic [WORD_W-1:0]           memRdData,
  output logic                        memWrEn,
  output logic [WORD_W-1:0]           memWrData,
  output logic [WORD_W*ACC_WORDS-1:0] accOut,
  output logic [WORD_W-1:0]           mulInA,
  output logic [WORD_W-1:0]           mulInB,
  output logic                        flagC,
  output logic                        flagZ,
  output logic                        flagN,
  output logic                        flagV
);
  mac_strobe_t strobe;

  mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .opMac(opMac), .opClr(opClr),
    .opShift(opShift), .opStore(opStore), .opMove(opMove),
    .moveFromAcc(moveFromAcc), .selA(selA), .selB(selB), .wrIdx(wrIdx),
    .strobe(strobe)
  );

  mac_datapath #(.WORD_W(WORD_W), .ACC_WORDS(ACC_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .s(strobe), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .accOut(accOut),
    .mulInA(mulInA), .mulInB(mulInB),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );
endmodule

// File: tb/mac_fwd_unit_tb.sv
`timescale 1ns/1ps
module mac_fwd_unit_tb;
  logic clk = 1'b0;
  logic rstN;
  logic rdIssue, opMac, opClr, opShift, opStore, opMove, moveFromAcc;
  logic [2:0] selA, selB;
  logic [1:0] wrIdx;
  logic [15:0] memRdData;
  logic memWrEn;
  logic [15:0] memWrData, mulInA, mulInB;
  logic [47:0] accOut;
  logic flagC, flagZ, flagN, flagV;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mac_fwd_unit u_dut (
    .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .opMac(opMac), .opClr(opClr),
    .opShift(opShift), .opStore(opStore), .opMove(opMove),
    .moveFromAcc(moveFromAcc), .selA(selA), .selB(selB), .wrIdx(wrIdx),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .accOut(accOut), .mulInA(mulInA), .mulInB(mulInB),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rdIssue = 0; opMac = 0; opClr = 0; opShift = 0; opStore = 0;
    opMove = 0; moveFromAcc = 0; selA = 0; selB = 0; wrIdx = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Read issued one cycle, word arrives and is moved the next (R4).
  task automatic loadReg(input logic [1:0] idx, input logic [15:0] val);
    idle(); rdIssue = 1; tick();
    idle(); memRdData = val; opMove = 1; wrIdx = idx; tick();
    idle();
  endtask

  task automatic clearAcc();
    idle(); opClr = 1; tick(); idle();
  endtask

  task automatic t_reset();
    check("R1 acc", accOut, 48'h0);
    check("R1 flags CZNV", {44'h0, flagC, flagZ, flagN, flagV}, 48'h4);
    check("R1 mulIn", {16'h0, mulInA, mulInB}, 48'h0);
    check("R1 memWrEn", {47'h0, memWrEn}, 48'h0);
  endtask

  task automatic t_macRegs();
    loadReg(0, 16'h1234);
    loadReg(1, 16'hABCD);
    clearAcc();
    opMac = 1; selA = 0; selB = 1; tick(); idle();
    check("R2 R4 single mac", accOut, 48'h1234 * 48'hABCD);
    opMac = 1; selA = 1; selB = 1; tick(); idle();
    check("R2 accumulate", accOut, 48'h1234 * 48'hABCD + 48'hABCD * 48'hABCD);
  endtask

  task automatic t_forward();
    logic [47:0] exp;
    clearAcc();
    // Overlap: multiply-accumulate while issuing a read (R6)
    opMac = 1; selA = 0; selB = 0; rdIssue = 1; tick(); idle();
    exp = 48'h1234 * 48'h1234;
    check("R6 mac during read", accOut, exp);
    memRdData = 16'h8001; opMac = 1; selA = 4; selB = 1; #1;
    check("R3 live forward operand", {32'h0, mulInA}, 48'h8001);
    tick(); idle();
    exp = exp + 48'h8001 * 48'hABCD;
    check("R3 R6 forwarded mac", accOut, exp);
    // No pending read: code 4 must use the captured word, not the bus
    memRdData = 16'h5555; opMac = 1; selA = 1; selB = 4; #1;
    check("R3 captured operand", {32'h0, mulInB}, 48'h8001);
    tick(); idle();
  endtask

  task automatic t_storeShift();
    logic [47:0] v;
    clearAcc();
    loadReg(2, 16'hFFFF);
    opMac = 1; selA = 2; selB = 2; tick(); idle();
    v = 48'hFFFE0001;
    opMac = 1; selA = 2; selB = 2; tick(); idle();
    v = v + 48'hFFFE0001;
    check("R2 two max products", accOut, v);
    for (int k = 0; k < 3; k++) begin
      opStore = 1; opShift = 1; #1;
      check("R5 store data", {32'h0, memWrData}, {32'h0, v[15:0]});
      check("R5 store strobe", {47'h0, memWrEn}, 48'h1);
      tick(); idle();
      v = v >> 16;
      check("R5 shift zero fill", accOut, v);
    end
    // shift combined with multiply: product added to shifted value
    opMac = 1; opShift = 1; selA = 2; selB = 2; tick(); idle();
    check("R5 shift plus mac", accOut, 48'hFFFE0001);
  endtask

  task automatic t_storeMove();
    logic [15:0] lo;
    lo = accOut[15:0];
    opStore = 1; opMove = 1; moveFromAcc = 1; wrIdx = 3; #1;
    check("R10 memory copy", {32'h0, memWrData}, {32'h0, lo});
    tick(); idle();
    opMac = 1; selA = 3; selB = 3; #1;
    check("R10 register copy", {32'h0, mulInA}, {32'h0, lo});
    tick(); idle();
  endtask

  task automatic t_clearPriority();
    opClr = 1; opMac = 1; opShift = 1; selA = 2; selB = 2; tick(); idle();
    check("R7 clear wins", accOut, 48'h0);
    check("R7 clear flags CZNV", {44'h0, flagC, flagZ, flagN, flagV}, 48'h4);
  endtask

  task automatic t_flagsHold();
    loadReg(0, 16'h0001);
    loadReg(1, 16'h8000);
    clearAcc();
    opMac = 1; selA = 0; selB = 1; tick(); idle();
    check("R8 negative", {44'h0, flagC, flagZ, flagN, flagV}, 48'h2);
    selA = 1; selB = 0; #1;
    check("R9 operand A held", {32'h0, mulInA}, 48'h0001);
    check("R9 operand B held", {32'h0, mulInB}, 48'h8000);
    tick(); idle();
    opShift = 1; tick(); idle();
    check("R8 flags kept on shift", {44'h0, flagC, flagZ, flagN, flagV}, 48'h2);
    loadReg(2, 16'h0000);
    opMac = 1; selA = 2; selB = 1; tick(); idle();
    check("R8 zero after mac", {44'h0, flagC, flagZ, flagN, flagV}, 48'h4);
  endtask

  task automatic t_carry();
    logic [48:0] model;
    logic [48:0] nxt;
    int errs = 0;
    int vSeen = 0;
    int cSeen = 0;
    loadReg(0, 16'hFFFF);
    loadReg(1, 16'hFFFF);
    clearAcc();
    model = '0;
    opMac = 1; selA = 0; selB = 1;
    for (int i = 0; i < 70000 && cSeen == 0; i++) begin
      tick();
      nxt = {1'b0, model[47:0]} + 49'hFFFE0001;
      if (flagC !== nxt[48]) errs++;
      if (flagV !== (!model[47] && nxt[47])) errs++;
      if (accOut !== nxt[47:0]) errs++;
      if (flagV) vSeen++;
      if (flagC) cSeen++;
      model = {1'b0, nxt[47:0]};
    end
    idle();
    check("R8 long run mismatches", 48'(errs), 48'h0);
    check("R8 overflow seen once", 48'(vSeen), 48'h1);
    check("R8 carry out of bit 47", 48'(cSeen), 48'h1);
    tick();
    check("R8 carry kept on idle", {47'h0, flagC}, 48'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 0;
    memRdData = 16'h0;
    idle();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    t_reset();
    t_macRegs();
    t_forward();
    t_storeShift();
    t_storeMove();
    t_clearPriority();
    t_flagsHold();
    t_carry();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule